// File: doc/BRIEF.md
# SDRAM Refresh Scheduler and Sequencer

This block owns the refresh duty of a two-bank SDRAM. A free-running interval timer charges a ledger of owed refresh commands. When commands are owed, the sequencer takes the command pins away from the host. It closes any open bank with a deactivate-all command and then issues auto-refresh commands spaced by the row-cycle time. In distributed mode each interval owes a small programmable group of commands. In burst mode each interval owes one command per row, issued back to back. Owed commands are never dropped: if the host holds the bus across several intervals, the debt accumulates and is paid in one run once the host lets go.

The host arbiter asks for the bus with `host_req` and owns it while `host_grant` is high. `busy` marks every cycle in which a refresh or self-refresh sequence holds the pins. A pending refresh wins over a new host request.

A level request, `selfref_req`, moves the device into self-refresh. In burst mode a full pass over all rows runs first. The entry command is then issued with clock-enable low, and clock-enable stays low until the request falls. On exit, clock-enable rises and the pins stay idle for the row-cycle time. A catch-up run follows before the host is granted again: a full pass in burst mode, or one group in distributed mode.

States:
- `ST_IDLE`: pins idle; decides between self-refresh, owed refresh and host.
- `ST_HOST`: host owns the bus.
- `ST_PRECH`: deactivate-all command.
- `ST_TRP_WAIT`: precharge recovery.
- `ST_REF`: auto-refresh command.
- `ST_TRC_WAIT`: row-cycle recovery.
- `ST_SR_ENTER`: self-refresh entry command.
- `ST_SR_HOLD`: clock-enable low.
- `ST_SR_EXIT`: clock-enable high, waiting out the row-cycle time.

Transitions:
- IDLE→PRECH when a sequence starts with a bank open.
- IDLE→REF when refresh is owed, or when a burst self-refresh entry starts, with all banks closed.
- IDLE→SR_ENTER for a distributed-mode entry with all banks closed.
- IDLE→HOST when a request arrives with nothing owed.
- HOST→IDLE when the request drops.
- PRECH→TRP_WAIT.
- TRP_WAIT and TRC_WAIT, once their timer is done, go to REF if commands are still owed, to SR_ENTER if an entry is pending, and otherwise to IDLE.
- REF→TRC_WAIT.
- SR_ENTER→SR_HOLD.
- SR_HOLD→SR_EXIT when the request falls.
- SR_EXIT→REF, or to IDLE when the catch-up amount is zero.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1, cke is 1, host_grant and busy are 0, and ref_cnt is 0.
- R2: An auto-refresh drives ras_n=0, cas_n=0, we_n=1 with cke=1. Each one advances ref_cnt by one, wrapping to 0 after NUM_ROWS-1.
- R3: If bank_open is nonzero when a sequence starts, its first command is a deactivate-all (ras_n=0, cas_n=1, we_n=0, addr[AP_BIT]=1). The next command follows exactly max(cfg_trp,2) cycles later. With bank_open zero, no deactivate is issued.
- R4: Within a sequence, the command after an auto-refresh comes exactly max(cfg_trc,2) cycles after it.
- R5: In distributed mode (cfg_burst_mode=0), each cfg_interval cycles of running timer owes cfg_group auto-refreshes. Intervals that pass while the host holds the bus are carried over and issued after release, before any new grant.
- R6: In burst mode (cfg_burst_mode=1), each expired interval owes NUM_ROWS auto-refreshes, issued in one sequence.
- R7: A selfref_req seen in idle leads to the entry command (ras_n=0, cas_n=0, we_n=1 with cke falling on that edge). In burst mode exactly NUM_ROWS auto-refreshes come first; in distributed mode none do.
- R8: While self-refresh lasts, cke stays 0, the pins stay idle (ras_n=cas_n=we_n=1), and host_req is never granted.
- R9: After selfref_req falls, cke rises and the first command comes exactly max(cfg_trc,2) cycles later. Before the next grant, NUM_ROWS auto-refreshes (burst) or cfg_group (distributed) are issued.
- R10: A host_req raised in idle with nothing owed is granted on the next cycle and stays granted while held. host_grant and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_mode | input | 1 | 1 = burst refresh, 0 = distributed |
| cfg_trc | input | TW | Row-cycle time in cycles (minimum 2 applied) |
| cfg_trp | input | TW | Precharge time in cycles (minimum 2 applied) |
| cfg_interval | input | IW | Cycles between refresh charges |
| cfg_group | input | GW | Commands owed per interval in distributed mode |
| bank_open | input | 2 | Banks currently open, one bit each |
| host_req | input | 1 | Host asks for the command bus |
| host_grant | output | 1 | Host owns the command bus |
| busy | output | 1 | A refresh or self-refresh sequence holds the bus |
| selfref_req | input | 1 | Level request to stay in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ba | output | 1 | Bank select (held 0) |
| addr | output | AW | Address; bit AP_BIT selects all banks on deactivate |
| ref_cnt | output | ROW_W | Auto-refresh commands issued, modulo NUM_ROWS |

## Verification
The interval engine is driven in both modes. Directed runs with one bank open, both open and none open show whether the deactivate is issued only when needed and with the right recovery gap. A host hold spanning three intervals, followed at once by a new request, separates a ledger that carries missed intervals from one that drops them. It also shows whether a new request can jump ahead of owed work. Self-refresh is entered and left in both modes, with the host requesting throughout. This separates the full pass before entry and after exit from the single group after exit, and checks that clock-enable stays low and no grant leaks out. Seeded random timing, group sizes and bank states then repeat the per-sequence counts and gap checks across many configurations.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOST,
        ST_PRECH,
        ST_TRP_WAIT,
        ST_REF,
        ST_TRC_WAIT,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rfs_state_e;

endpackage

// File: rtl/rfs_interval_timer.sv
// Periodic tick generator: one tick every 'period' cycles while enabled.
module rfs_interval_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [IW-1:0] period,
    output logic          tick
);
    logic [IW-1:0] cnt;
    logic [IW-1:0] last;

    // A period of zero behaves as one.
    always_comb last = (period == '0) ? '0 : period - IW'(1);

    assign tick = en && (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + IW'(1);
        end
    end
endmodule

// File: rtl/rfs_owed_ledger.sv
// Saturating count of refresh commands still owed.
module rfs_owed_ledger #(
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [OW-1:0] load_val,
    input  logic          add,
    input  logic [OW-1:0] add_val,
    input  logic          dec,
    output logic [OW-1:0] owed
);
    logic [OW:0] sum;

    always_comb begin
        sum = {1'b0, owed} + (add ? {1'b0, add_val} : '0);
        if (dec && (sum != '0)) begin
            sum = sum - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else if (load) begin
            owed <= load_val;
        end else if (sum[OW]) begin
            owed <= '1;
        end else begin
            owed <= sum[OW-1:0];
        end
    end
endmodule

// File: rtl/rfs_wait_timer.sv
// Down-counter for recovery gaps; done while the count is zero.
module rfs_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!done) begin
            cnt <= cnt - TW'(1);
        end
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int NUM_ROWS = 4096,
    parameter int TW       = 8,
    parameter int IW       = 16,
    parameter int GW       = 4,
    parameter int AW       = 13,
    parameter int AP_BIT   = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_burst_mode,
    input  logic [TW-1:0]               cfg_trc,
    input  logic [TW-1:0]               cfg_trp,
    input  logic [IW-1:0]               cfg_interval,
    input  logic [GW-1:0]               cfg_group,
    input  logic [1:0]                  bank_open,
    input  logic                        host_req,
    output logic                        host_grant,
    output logic                        busy,
    input  logic                        selfref_req,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        we_n,
    output logic                        cke,
    output logic                        ba,
    output logic [AW-1:0]               addr,
    output logic [$clog2(NUM_ROWS)-1:0] ref_cnt
);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam int OW    = ROW_W + 4;

    rfs_state_e state, state_nxt;

    logic          sr_goal;
    logic          goal_set, goal_clr;
    logic          wt_load, wt_done;
    logic [TW-1:0] wt_val;
    logic          ow_clr, ow_load;
    logic [OW-1:0] ow_load_val, owed, charge_amt;
    logic          tick, tmr_en, ref_issue;
    logic [TW-1:0] eff_trc, eff_trp;
    logic [ROW_W-1:0] ref_nxt;
    logic          in_sr;

    // Gaps below two cycles are raised to two.
    always_comb eff_trc = (cfg_trc < TW'(2)) ? TW'(2) : cfg_trc;
    always_comb eff_trp = (cfg_trp < TW'(2)) ? TW'(2) : cfg_trp;

    // One interval owes a whole pass in burst mode, one group otherwise.
    always_comb charge_amt = cfg_burst_mode ? OW'(NUM_ROWS) : OW'(cfg_group);

    assign in_sr     = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) || (state == ST_SR_EXIT);
    assign tmr_en    = !sr_goal && !in_sr;
    assign ref_issue = (state == ST_REF);

    rfs_interval_timer #(.IW(IW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tmr_en),
        .period (cfg_interval),
        .tick   (tick)
    );

    rfs_owed_ledger #(.OW(OW)) u_ledger (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ow_clr),
        .load     (ow_load),
        .load_val (ow_load_val),
        .add      (tick),
        .add_val  (charge_amt),
        .dec      (ref_issue),
        .owed     (owed)
    );

    rfs_wait_timer #(.TW(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .done     (wt_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Pending self-refresh entry
    always_ff @(posedge clk) begin
        if (!rst_n || goal_clr) begin
            sr_goal <= 1'b0;
        end else if (goal_set) begin
            sr_goal <= 1'b1;
        end
    end

    // Refresh index, wrapping at NUM_ROWS
    generate
        if (NUM_ROWS == (1 << ROW_W)) begin : g_wrap_pow2
            assign ref_nxt = ref_cnt + ROW_W'(1);
        end else begin : g_wrap_mod
            assign ref_nxt = (ref_cnt == ROW_W'(NUM_ROWS - 1)) ? '0 : ref_cnt + ROW_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (ref_issue) begin
            ref_cnt <= ref_nxt;
        end
    end

    // Next state and sequencing strobes
    always_comb begin
        state_nxt   = state;
        wt_load     = 1'b0;
        wt_val      = '0;
        ow_clr      = 1'b0;
        ow_load     = 1'b0;
        ow_load_val = '0;
        goal_set    = 1'b0;
        goal_clr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (selfref_req) begin
                    goal_set = 1'b1;
                    if (cfg_burst_mode) begin
                        ow_load     = 1'b1;
                        ow_load_val = OW'(NUM_ROWS);
                    end else begin
                        ow_clr = 1'b1;
                    end
                    if (bank_open != 2'b00) begin
                        state_nxt = ST_PRECH;
                    end else if (cfg_burst_mode) begin
                        state_nxt = ST_REF;
                    end else begin
                        state_nxt = ST_SR_ENTER;
                    end
                end else if (owed != '0) begin
                    state_nxt = (bank_open != 2'b00) ? ST_PRECH : ST_REF;
                end else if (host_req) begin
                    state_nxt = ST_HOST;
                end
            end
            ST_HOST: begin
                if (!host_req) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_PRECH: begin
                wt_load   = 1'b1;
                wt_val    = eff_trp - TW'(2);
                state_nxt = ST_TRP_WAIT;
            end
            ST_REF: begin
                wt_load   = 1'b1;
                wt_val    = eff_trc - TW'(2);
                state_nxt = ST_TRC_WAIT;
            end
            ST_TRP_WAIT, ST_TRC_WAIT: begin
                if (wt_done) begin
                    if (owed != '0) begin
                        state_nxt = ST_REF;
                    end else if (sr_goal) begin
                        state_nxt = ST_SR_ENTER;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            ST_SR_ENTER: begin
                goal_clr  = 1'b1;
                ow_clr    = 1'b1;
                state_nxt = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (!selfref_req) begin
                    wt_load   = 1'b1;
                    wt_val    = eff_trc - TW'(1);
                    state_nxt = ST_SR_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (wt_done) begin
                    ow_load     = 1'b1;
                    ow_load_val = charge_amt;
                    state_nxt   = (charge_amt != '0) ? ST_REF : ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Pin decode
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        cke   = 1'b1;
        ba    = 1'b0;
        addr  = '0;
        unique case (state)
            ST_PRECH: begin
                ras_n        = 1'b0;
                we_n         = 1'b0;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            ST_SR_ENTER: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                cke   = 1'b0;
            end
            ST_SR_HOLD: begin
                cke = 1'b0;
            end
            default: ;
        endcase
    end

    assign host_grant = (state == ST_HOST);
    assign busy       = (state != ST_HOST) && (state != ST_IDLE);

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             cke,
    input logic             host_req,
    input logic             host_grant,
    input logic             busy,
    input logic [ROW_W-1:0] ref_cnt
);
    // R10: host and sequencer never own the pins together
    a_r10_grant_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_grant && busy));

    // R10: a grant follows a request sampled on the previous edge
    a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |-> $past(host_req));

    // R2: each auto-refresh advances the index by one
    a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !ras_n && !cas_n && we_n) |=> (ref_cnt == $past(ref_cnt) + 1'b1));

    // R7: clock-enable falls only together with the entry command
    a_r7_entry_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!ras_n && !cas_n && we_n));

    // R8: pins idle while clock-enable is held low
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (ras_n && cas_n && we_n));

    // R8: no grant during self-refresh
    a_r8_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !host_grant);

    // R9: no command on the cycle clock-enable returns
    a_r9_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (ras_n && cas_n && we_n));
endmodule

bind sdram_refresh_seq rfs_checker #(.ROW_W(ROW_W)) u_rfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cke        (cke),
    .host_req   (host_req),
    .host_grant (host_grant),
    .busy       (busy),
    .ref_cnt    (ref_cnt)
);

// File: tb/tb_sdram_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdram_refresh_seq;
    localparam int NR = 16;
    localparam int TW = 8;
    localparam int IW = 16;
    localparam int GW = 4;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_burst_mode = 1'b0;
    logic [TW-1:0] cfg_trc = 8'd3;
    logic [TW-1:0] cfg_trp = 8'd2;
    logic [IW-1:0] cfg_interval = 16'd60;
    logic [GW-1:0] cfg_group = 4'd2;
    logic [1:0] bank_open = 2'b00;
    logic host_req = 1'b0;
    logic selfref_req = 1'b0;
    logic host_grant, busy, ras_n, cas_n, we_n, cke, ba;
    logic [AW-1:0] addr;
    logic [$clog2(NR)-1:0] ref_cnt;

    always #2 clk = ~clk;

    sdram_refresh_seq #(.NUM_ROWS(NR), .TW(TW), .IW(IW), .GW(GW), .AW(AW), .AP_BIT(10)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_mode(cfg_burst_mode), .cfg_trc(cfg_trc),
        .cfg_trp(cfg_trp), .cfg_interval(cfg_interval), .cfg_group(cfg_group),
        .bank_open(bank_open), .host_req(host_req), .host_grant(host_grant), .busy(busy),
        .selfref_req(selfref_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .ba(ba), .addr(addr), .ref_cnt(ref_cnt)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gap(logic [TW-1:0] v);
        return (v < 2) ? 2 : int'(v);
    endfunction

    // ---------------- monitor ----------------
    int cyc = 0, last_cyc = 0, last_kind = 0, seq_refs = 0, tot_refs = 0, rise_cyc = 0;
    bit prev_busy = 0, prev_cke = 1, first_pend = 0, exp_pre = 0, after_exit = 0;
    bit is_ref, is_pre, is_sre;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_busy = 0; prev_cke = 1; last_kind = 0;
            first_pend = 0; after_exit = 0; seq_refs = 0;
        end else begin
            cyc++;
            is_ref = cke && !ras_n && !cas_n && we_n;
            is_pre = cke && !ras_n && cas_n && !we_n;
            is_sre = !cke && prev_cke && !ras_n && !cas_n && we_n;
            if (busy && !prev_busy) begin
                seq_refs = 0; first_pend = 1; exp_pre = (bank_open != 2'b00); last_kind = 0;
            end
            if (!busy && prev_busy) last_kind = 0;
            if (cke && !prev_cke) begin
                rise_cyc = cyc; after_exit = 1;
            end
            if (is_ref || is_pre || is_sre) begin
                if (first_pend) begin
                    chk(is_pre == exp_pre, "R3 deactivate first only if a bank is open", is_pre, exp_pre);
                    if (is_pre) chk(addr[10] == 1'b1, "R3 all-bank address bit", addr[10], 1);
                    first_pend = 0;
                end
                if (last_kind == 1)
                    chk(cyc - last_cyc == gap(cfg_trp), "R3 deactivate gap", cyc - last_cyc, gap(cfg_trp));
                else if (last_kind == 2)
                    chk(cyc - last_cyc == gap(cfg_trc), "R4 refresh gap", cyc - last_cyc, gap(cfg_trc));
                if (after_exit) begin
                    chk(cyc - rise_cyc == gap(cfg_trc), "R9 exit quiet time", cyc - rise_cyc, gap(cfg_trc));
                    after_exit = 0;
                end
                last_kind = is_pre ? 1 : (is_ref ? 2 : 0);
                last_cyc = cyc;
                if (is_ref) begin
                    seq_refs++; tot_refs++;
                end
            end
            if (host_grant && busy) chk(0, "R10 grant during busy", 1, 0);
            prev_busy = busy; prev_cke = cke;
        end
    end

    // ---------------- helpers ----------------
    task automatic do_reset();
        rst_n = 1'b0; host_req = 1'b0; selfref_req = 1'b0;
        repeat (3) @(negedge clk);
        chk({ras_n, cas_n, we_n, cke, host_grant, busy} == 6'b111100, "R1 reset pins",
            {ras_n, cas_n, we_n, cke, host_grant, busy}, 6'b111100);
        chk(ref_cnt == 0, "R1 reset index", ref_cnt, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_busy(bit lvl);
        do @(negedge clk); while (busy !== lvl);
    endtask

    task automatic host_pulse(int len);
        host_req = 1'b1;
        @(negedge clk);
        chk(host_grant == 1'b1, "R10 grant next cycle", host_grant, 1);
        repeat (len - 1) @(negedge clk);
        chk(host_grant == 1'b1, "R10 grant held", host_grant, 1);
        host_req = 1'b0;
        @(negedge clk);
        chk(host_grant == 1'b0, "R10 grant released", host_grant, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin : main
        int unsigned sd;
        int r0, n, exp_n;
        bit ok;
        sd = $urandom(32'd2024);

        // Distributed mode, one bank open
        cfg_burst_mode = 0; cfg_trc = 3; cfg_trp = 2; cfg_interval = 60; cfg_group = 2;
        do_reset();
        bank_open = 2'b01;
        wait_busy(1); wait_busy(0);
        chk(seq_refs == 2, "R5 group size per interval", seq_refs, 2);
        chk(ref_cnt == 2, "R2 index after group", ref_cnt, 2);

        // Carry-over across a long host hold, then an immediate new request
        bank_open = 2'b00;
        host_req = 1'b1;
        @(negedge clk);
        chk(host_grant == 1'b1, "R10 grant when nothing owed", host_grant, 1);
        repeat (180) @(negedge clk);
        r0 = tot_refs;
        host_req = 1'b0;
        @(negedge clk);
        host_req = 1'b1;
        do @(negedge clk); while (!host_grant);
        n = tot_refs - r0;
        chk(n == 6 || n == 8, "R5 carried intervals paid before regrant", n, 6);
        host_req = 1'b0;
        @(negedge clk);

        // Burst mode, both banks open
        cfg_burst_mode = 1; cfg_trc = 4; cfg_trp = 3; cfg_interval = 150;
        do_reset();
        bank_open = 2'b11;
        wait_busy(1); wait_busy(0);
        chk(seq_refs == NR, "R6 full pass per interval", seq_refs, NR);
        chk(ref_cnt == 0, "R2 index wraps after full pass", ref_cnt, 0);

        // Burst-mode self-refresh
        bank_open = 2'b10;
        r0 = tot_refs;
        selfref_req = 1'b1;
        do @(negedge clk); while (cke);
        chk(tot_refs - r0 == NR, "R7 full pass before entry", tot_refs - r0, NR);
        chk({ras_n, cas_n, we_n} == 3'b001, "R7 entry encoding", {ras_n, cas_n, we_n}, 1);
        host_req = 1'b1;
        ok = 1;
        repeat (40) begin
            @(negedge clk);
            if (cke || !ras_n || !cas_n || !we_n || host_grant) ok = 0;
        end
        chk(ok, "R8 hold low, idle, no grant", ok, 1);
        r0 = tot_refs;
        selfref_req = 1'b0;
        bank_open = 2'b00;
        do @(negedge clk); while (!host_grant);
        chk(tot_refs - r0 == NR, "R9 full pass after exit", tot_refs - r0, NR);
        host_req = 1'b0;
        @(negedge clk);

        // Distributed-mode self-refresh
        cfg_burst_mode = 0; cfg_trc = 2; cfg_trp = 4; cfg_interval = 80; cfg_group = 3;
        do_reset();
        bank_open = 2'b00;
        wait_busy(1); wait_busy(0);
        chk(seq_refs == 3, "R5 group of three", seq_refs, 3);
        r0 = tot_refs;
        selfref_req = 1'b1;
        do @(negedge clk); while (cke);
        chk(tot_refs - r0 == 0, "R7 no pass before distributed entry", tot_refs - r0, 0);
        repeat (20) @(negedge clk);
        chk(cke == 1'b0, "R8 still in self-refresh", cke, 0);
        r0 = tot_refs;
        selfref_req = 1'b0;
        host_req = 1'b1;
        do @(negedge clk); while (!host_grant);
        chk(tot_refs - r0 == 3, "R9 one group after exit", tot_refs - r0, 3);
        host_req = 1'b0;
        @(negedge clk);

        // Seeded random configurations
        for (int it = 0; it < 12; it++) begin
            cfg_burst_mode = $urandom_range(0, 1);
            cfg_trc = TW'($urandom_range(0, 6));
            cfg_trp = TW'($urandom_range(0, 5));
            cfg_group = GW'($urandom_range(1, 3));
            cfg_interval = cfg_burst_mode ? IW'(NR * gap(cfg_trc) + gap(cfg_trp) + 30)
                                          : IW'(3 * gap(cfg_trc) + gap(cfg_trp) + 30);
            exp_n = cfg_burst_mode ? NR : int'(cfg_group);
            do_reset();
            bank_open = 2'($urandom_range(0, 3));
            wait_busy(1); wait_busy(0);
            chk(seq_refs == exp_n, cfg_burst_mode ? "R6 random pass" : "R5 random group", seq_refs, exp_n);
            chk(ref_cnt == (exp_n % NR), "R2 random index", ref_cnt, exp_n % NR);
            bank_open = 2'($urandom_range(0, 3));
            host_pulse($urandom_range(1, 8));
            wait_busy(1); wait_busy(0);
            chk(seq_refs == exp_n, cfg_burst_mode ? "R6 random second pass" : "R5 random second group", seq_refs, exp_n);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule